// File: doc/BRIEF.md
# Lateral Guarded Mode Controller

This block tracks whether a processor core running at kernel privilege is in its normal mode or in a guarded mode. The guarded mode sits beside the normal mode at the same privilege level and is not a higher level. It shares the page tables of the normal mode, but its accesses are judged against a different set of permission bits. The decoder hands the controller a one-cycle strobe for each enter or exit instruction. The controller answers with a program-counter redirect, or it raises an undefined-instruction flag when the instruction is not legal in the current state.

The guarded mode has its own bank of exception-context registers: a return-address register, a syndrome register, a fault-address register, a saved status register, a vector base, a thread-pointer register and an auxiliary status register. A programmable entry-vector register sits in the same bank. Software reaches every one of these through a 64-bit system-register port with a 3-bit select. An enter instruction jumps to the entry vector. An exit instruction jumps to the banked return address. Bit 0 of the auxiliary status register decides whether that exit lands in normal mode (0) or stays in guarded mode (1).

Guarded mode can only be entered while bit 1 of the configuration word is set.

Top module: `gmode_ctrl`

## Requirements
- R1: After reset the controller is in normal mode (`in_guarded`=0), `redir_valid`, `undef_insn` and `redir_pc` are 0, and every banked register reads back as 0.
- R2: A write on the register port (select encoding: 0 entry vector, 1 return address, 2 saved status, 3 auxiliary status, 4 syndrome, 5 fault address, 6 vector base, 7 thread pointer) takes effect at the clock edge where `reg_we` is high. A read strobe returns data on `reg_rdata` one cycle later. A read issued in the same cycle as a write to the same select returns the old value. `reg_rdata` holds its value while no read is issued.
- R3: With bit 1 of `cfg_word` set, a lone enter strobe in normal mode switches to guarded mode. One cycle later it pulses `redir_valid` with `redir_pc` equal to the entry vector (select 0).
- R4: With bit 1 of `cfg_word` clear, an enter strobe leaves the mode unchanged, gives no redirect, and pulses `undef_insn`.
- R5: A lone exit strobe in guarded mode with bit 0 of the auxiliary status register clear returns to normal mode. It redirects to the banked return address (select 1).
- R6: A lone exit strobe in guarded mode with bit 0 of the auxiliary status register set keeps guarded mode. It still redirects to the banked return address.
- R7: Three cases pulse `undef_insn`, give no redirect and leave the mode unchanged: an enter in guarded mode, an exit in normal mode, or enter and exit strobed together.
- R8: `redir_valid` and `undef_insn` are one-cycle pulses. `redir_pc` holds its last redirect target between redirects.
- R9: A register write in the same cycle as an enter or exit does not affect that instruction's redirect target or exit decision. The old value is used.
- R10: Writing one banked register leaves the other seven unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 8 | Configuration word; bit 1 enables guarded mode |
| op_enter | input | 1 | Decoded enter-instruction strobe |
| op_exit | input | 1 | Decoded exit-instruction strobe |
| reg_we | input | 1 | Banked register write enable |
| reg_re | input | 1 | Banked register read strobe |
| reg_sel | input | 3 | Banked register select |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Registered read data |
| redir_valid | output | 1 | One-cycle redirect pulse |
| redir_pc | output | 64 | Redirect target |
| in_guarded | output | 1 | Current mode, 1 = guarded |
| undef_insn | output | 1 | One-cycle undefined-instruction pulse |

## Verification
Every result of this block is due exactly one rising edge after the stimulus that causes it. The mode flag, the redirect pulse and target, and the undefined flag all follow an enter or exit by one edge. Read data follows a read strobe by one edge. A write becomes visible to a read or an instruction issued in the next cycle. The bench drives inputs on the falling edge and lets one rising edge pass. It updates its own model at that edge from the pre-edge state, and compares every output at the following falling edge. This puts same-cycle write-and-use cases on the old value.

// File: rtl/gmode_pkg.sv
package gmode_pkg;
  localparam int BANK_SEL_W = 3;
  localparam int BANK_N     = 1 << BANK_SEL_W;

  typedef enum logic [BANK_SEL_W-1:0] {
    SEL_ENTRY  = 3'd0,
    SEL_RETADR = 3'd1,
    SEL_SAVSTS = 3'd2,
    SEL_AUXSTS = 3'd3,
    SEL_SYNDRM = 3'd4,
    SEL_FLTADR = 3'd5,
    SEL_VECBAS = 3'd6,
    SEL_THRPTR = 3'd7
  } bank_sel_e;

  typedef struct packed {
    logic ok_enter;
    logic ok_exit;
    logic undef;
  } op_dec_t;
endpackage

// File: rtl/gmode_check.sv
module gmode_check
  import gmode_pkg::*;
(
  input  logic    op_enter,
  input  logic    op_exit,
  input  logic    guarded,
  input  logic    gl_en,
  output op_dec_t dec
);
  logic lone_enter;
  logic lone_exit;

  always_comb begin
    lone_enter   = op_enter & ~op_exit;
    lone_exit    = op_exit & ~op_enter;
    dec.ok_enter = lone_enter & ~guarded & gl_en;
    dec.ok_exit  = lone_exit & guarded;
    dec.undef    = (op_enter | op_exit) & ~(dec.ok_enter | dec.ok_exit);
  end
endmodule

// File: rtl/gmode_bank.sv
module gmode_bank
  import gmode_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int STAY_BIT = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic                  re,
  input  logic [BANK_SEL_W-1:0] sel,
  input  logic [XLEN-1:0]       wdata,
  output logic [XLEN-1:0]       rdata,
  output logic [XLEN-1:0]       entry_q,
  output logic [XLEN-1:0]       retadr_q,
  output logic                  stay_q
);
  logic [XLEN-1:0] regs [BANK_N];
  logic [BANK_N-1:0] hit;

  for (genvar gi = 0; gi < BANK_N; gi++) begin : g_hit
    assign hit[gi] = we && (sel == BANK_SEL_W'(gi));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < BANK_N; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < BANK_N; i++) begin
        if (hit[i]) regs[i] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (re) rdata <= regs[sel];
  end

  assign entry_q  = regs[SEL_ENTRY];
  assign retadr_q = regs[SEL_RETADR];
  assign stay_q   = regs[SEL_AUXSTS][STAY_BIT];

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdata)); // R2
  AST_RETADR_WRITE: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SEL_RETADR) |=> (retadr_q == $past(wdata))); // R2
  AST_ENTRY_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
    !(we && sel == SEL_ENTRY) |=> $stable(entry_q)); // R10
endmodule

// File: rtl/gmode_fsm.sv
module gmode_fsm
  import gmode_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  op_dec_t         dec,
  input  logic [XLEN-1:0] entry_q,
  input  logic [XLEN-1:0] retadr_q,
  input  logic            stay_q,
  output logic            guarded,
  output logic            redir_valid,
  output logic [XLEN-1:0] redir_pc,
  output logic            undef
);
  always_ff @(posedge clk) begin
    if (rst) begin
      guarded     <= 1'b0;
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      undef       <= 1'b0;
    end else begin
      redir_valid <= dec.ok_enter | dec.ok_exit;
      undef       <= dec.undef;
      if (dec.ok_enter) begin
        guarded  <= 1'b1;
        redir_pc <= entry_q;
      end else if (dec.ok_exit) begin
        guarded  <= stay_q;
        redir_pc <= retadr_q;
      end
    end
  end

  AST_REDIR_XOR_UNDEF: assert property (@(posedge clk) disable iff (rst)
    !(redir_valid && undef)); // R7
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(dec.ok_enter || dec.ok_exit) |=> $stable(redir_pc)); // R8
endmodule

// File: rtl/gmode_ctrl.sv
module gmode_ctrl
  import gmode_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int CFG_W     = 8,
  parameter int GL_EN_BIT = 1,
  parameter int STAY_BIT  = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CFG_W-1:0]      cfg_word,
  input  logic                  op_enter,
  input  logic                  op_exit,
  input  logic                  reg_we,
  input  logic                  reg_re,
  input  logic [BANK_SEL_W-1:0] reg_sel,
  input  logic [XLEN-1:0]       reg_wdata,
  output logic [XLEN-1:0]       reg_rdata,
  output logic                  redir_valid,
  output logic [XLEN-1:0]       redir_pc,
  output logic                  in_guarded,
  output logic                  undef_insn
);
  op_dec_t         dec;
  logic [XLEN-1:0] entry_q;
  logic [XLEN-1:0] retadr_q;
  logic            stay_q;
  logic            gl_en;
  logic            unused_cfg;

  assign gl_en      = cfg_word[GL_EN_BIT];
  assign unused_cfg = ^cfg_word;

  gmode_check u_check (
    .op_enter (op_enter),
    .op_exit  (op_exit),
    .guarded  (in_guarded),
    .gl_en    (gl_en),
    .dec      (dec)
  );

  gmode_bank #(.XLEN(XLEN), .STAY_BIT(STAY_BIT)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .we       (reg_we),
    .re       (reg_re),
    .sel      (reg_sel),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .entry_q  (entry_q),
    .retadr_q (retadr_q),
    .stay_q   (stay_q)
  );

  gmode_fsm #(.XLEN(XLEN)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .dec         (dec),
    .entry_q     (entry_q),
    .retadr_q    (retadr_q),
    .stay_q      (stay_q),
    .guarded     (in_guarded),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc),
    .undef       (undef_insn)
  );

  AST_ENTER_OK: assert property (@(posedge clk) disable iff (rst)
    (op_enter && !op_exit && !in_guarded && gl_en) |=> (in_guarded && redir_valid)); // R3
  AST_ENTER_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (op_enter && !op_exit && !in_guarded && !gl_en) |=> (!in_guarded && !redir_valid && undef_insn)); // R4
  AST_EXIT_TO_NORMAL: assert property (@(posedge clk) disable iff (rst)
    (op_exit && !op_enter && in_guarded && !stay_q) |=> (!in_guarded && redir_valid)); // R5
  AST_EXIT_STAY: assert property (@(posedge clk) disable iff (rst)
    (op_exit && !op_enter && in_guarded && stay_q) |=> (in_guarded && redir_valid)); // R6
  AST_BOTH_STROBES: assert property (@(posedge clk) disable iff (rst)
    (op_enter && op_exit) |=> (undef_insn && !redir_valid && $stable(in_guarded))); // R7
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
    (!op_enter && !op_exit) |=> (!redir_valid && !undef_insn)); // R8
endmodule

// File: tb/gmode_ctrl_test.sv
module gmode_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  cfg_word;
  logic        op_enter, op_exit, reg_we, reg_re;
  logic [2:0]  reg_sel;
  logic [63:0] reg_wdata;
  logic [63:0] reg_rdata;
  logic        redir_valid;
  logic [63:0] redir_pc;
  logic        in_guarded;
  logic        undef_insn;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [63:0] m_bank [8];
  logic        m_g, m_rv, m_ud;
  logic [63:0] m_pc, m_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  gmode_ctrl uut (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .op_enter(op_enter), .op_exit(op_exit),
    .reg_we(reg_we), .reg_re(reg_re), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .in_guarded(in_guarded), .undef_insn(undef_insn)
  );

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_bank[i] = '0;
    m_g = 0; m_rv = 0; m_ud = 0; m_pc = '0; m_rd = '0;
  endtask

  task automatic model_edge();
    logic ok_en, ok_ex;
    ok_en = op_enter && !op_exit && !m_g && cfg_word[1];
    ok_ex = op_exit && !op_enter && m_g;
    m_rv = ok_en || ok_ex;
    m_ud = (op_enter || op_exit) && !(ok_en || ok_ex);
    if (ok_en) begin m_g = 1; m_pc = m_bank[0]; end
    else if (ok_ex) begin m_g = m_bank[3][0]; m_pc = m_bank[1]; end
    if (reg_re) m_rd = m_bank[reg_sel];
    if (reg_we) m_bank[reg_sel] = reg_wdata;
  endtask

  function automatic string tag_of();
    if (op_enter && op_exit) return "R7";
    if (op_enter) return m_g ? "R7" : (cfg_word[1] ? "R3" : "R4");
    if (op_exit) return !m_g ? "R7" : (m_bank[3][0] ? "R6" : "R5");
    return "R8";
  endfunction

  task automatic idle();
    op_enter = 0; op_exit = 0; reg_we = 0; reg_re = 0; reg_sel = '0; reg_wdata = '0;
  endtask

  task automatic step(string tag);
    string t;
    t = (tag == "") ? tag_of() : tag;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(t, "in_guarded", 64'(in_guarded), 64'(m_g));
    chk(t, "redir_valid", 64'(redir_valid), 64'(m_rv));
    chk(t, "undef_insn", 64'(undef_insn), 64'(m_ud));
    chk(t, "redir_pc", redir_pc, m_pc);
    chk((t == "R8") ? "R2" : t, "reg_rdata", reg_rdata, m_rd);
    idle();
  endtask

  task automatic wr(int sel, logic [63:0] d, string tag);
    reg_we = 1; reg_sel = 3'(sel); reg_wdata = d; step(tag);
  endtask

  task automatic rd(int sel, string tag);
    reg_re = 1; reg_sel = 3'(sel); step(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd20240611);
    idle();
    cfg_word = 8'h00;
    rst = 1;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state and all banked registers read zero
    chk("R1", "in_guarded", 64'(in_guarded), 0);
    chk("R1", "redir_valid", 64'(redir_valid), 0);
    chk("R1", "undef_insn", 64'(undef_insn), 0);
    chk("R1", "redir_pc", redir_pc, 0);
    for (int i = 0; i < 8; i++) rd(i, "R1");
    // R10 / R2: distinct writes, each read back
    for (int i = 0; i < 8; i++) wr(i, 64'hA5A5_0000_0000_0000 | 64'(i * 16 + 2), "R10");
    for (int i = 0; i < 8; i++) rd(i, "R10");
    // R2: same-cycle read of a register being written returns old value
    reg_we = 1; reg_re = 1; reg_sel = 3'd4; reg_wdata = 64'hDEAD_BEEF_0000_1111; step("R2");
    rd(4, "R2");
    // R4: enter while disabled
    op_enter = 1; step("R4");
    cfg_word = 8'h02;
    // R3: enter enabled; R8: pulse ends
    op_enter = 1; step("R3");
    step("R8");
    // R7: enter while guarded
    op_enter = 1; step("R7");
    // R6: exit staying guarded
    wr(3, 64'h1, "R6");
    op_exit = 1; step("R6");
    // R9: exit decision uses old aux status despite same-cycle write
    op_exit = 1; reg_we = 1; reg_sel = 3'd3; reg_wdata = 64'h0; step("R9");
    // R5: exit to normal, with return address changed first
    wr(1, 64'h0000_0040_1234_5678, "R5");
    op_exit = 1; step("R5");
    // R7: exit in normal, both strobes
    op_exit = 1; step("R7");
    op_enter = 1; op_exit = 1; step("R7");
    // R9: enter with same-cycle entry-vector write uses old vector
    op_enter = 1; reg_we = 1; reg_sel = 3'd0; reg_wdata = 64'hFFFF_0000_FFFF_0000; step("R9");
    op_exit = 1; step("R9");
    op_enter = 1; step("R9");
    op_exit = 1; step("");
    // random phase
    for (int n = 0; n < 4000; n++) begin
      int unsigned r;
      r = $urandom % 16;
      cfg_word = 8'($urandom);
      if (r < 10) cfg_word[1] = 1'b1;
      op_enter = (r inside {0, 1, 2, 3});
      op_exit  = (r inside {3, 4, 5, 6});
      reg_we = ($urandom % 3) == 0;
      reg_re = ($urandom % 2) == 0;
      reg_sel = 3'($urandom);
      reg_wdata = {$urandom, $urandom};
      step("");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule